// File: doc/BRIEF.md
# Multiply, Divide and Accumulate Unit

A multi-cycle arithmetic unit that sits beside a small register file of four 16-bit register pairs (here called AX, BC, DE and HL) and a 32-bit accumulator. A request names an operation and presents the current register contents. The unit captures the operands on the edge that accepts the request, works for a fixed number of clocks that depends on the operation, and then raises `done` for one cycle. In that same cycle it presents the new register values together with one write enable per destination. The surrounding core owns the registers and writes back whatever is enabled.

The unit covers:
- an 8x8 unsigned multiply of the two bytes of AX;
- 16x16 signed and unsigned multiplies with a 32-bit result;
- 16-bit and 32-bit unsigned divides, built as restoring shift-and-subtract that retires two quotient bits per clock;
- signed and unsigned multiply-accumulate into the 32-bit accumulator, each producing a carry flag and an auxiliary-carry flag.

Both divides share one datapath. A zero divisor gives an all-ones quotient and returns the dividend as the remainder.

Top module: `md_arith_unit`

## Requirements
- R1: With `op_sel`=0 (byte multiply), the high byte of AX times the low byte of AX, unsigned, is written to AX. `done` comes 1 clock after acceptance, counting the accepting edge.
- R2: With `op_sel`=1 (signed word multiply), AX and BC are multiplied as two's-complement values. The upper half of the 32-bit product goes to BC and the lower half to AX, 2 clocks after acceptance.
- R3: With `op_sel`=2 (unsigned word multiply), the unsigned product of AX and BC is split the same way (upper half to BC, lower half to AX), 2 clocks after acceptance.
- R4: With `op_sel`=3 (short divide), AX is divided by DE, unsigned. The quotient goes to AX and the remainder to DE, 9 clocks after acceptance. If DE is 0, AX becomes 0xFFFF and DE receives the original AX.
- R5: With `op_sel`=4 (long divide), {BC,AX} is divided by {HL,DE}, unsigned. The quotient goes to {BC,AX} and the remainder to {HL,DE}, 17 clocks after acceptance. If the divisor is 0, BC and AX both become 0xFFFF and {HL,DE} receives the dividend.
- R6: With `op_sel`=5 (signed accumulate), the signed product of AX and BC is added to the accumulator, 3 clocks after acceptance. Carry is set when bit 31 of the accumulator changes. Auxiliary carry equals bit 31 of the new value.
- R7: With `op_sel`=6 (unsigned accumulate), the unsigned product is added to the accumulator modulo 2^32, 3 clocks after acceptance. Carry is set when the new value is less than the old value. Auxiliary carry is cleared.
- R8: `done` is high for exactly one cycle per operation. The write enables pulse only in that cycle:
  - byte multiply enables AX;
  - the word multiplies enable AX and BC;
  - the short divide enables AX and DE;
  - the long divide enables all four pairs;
  - the accumulates enable the accumulator and the flags.
- R9: A request made while an operation is in progress has no effect on that operation and produces no extra result. A request with `op_sel`=7 is ignored.
- R10: Every result output and flag holds its value from one `done` until a later `done` replaces it. Outputs that an operation does not enable keep their previous values.
- R11: While reset is asserted, `busy`, `done`, all write enables, both flags and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled on the rising edge |
| op_sel | input | 3 | Operation code (0..6; 7 is ignored) |
| ax_i | input | 16 | Current AX |
| bc_i | input | 16 | Current BC |
| de_i | input | 16 | Current DE |
| hl_i | input | 16 | Current HL |
| acc_i | input | 32 | Current accumulator |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ax_o | output | 16 | New AX |
| bc_o | output | 16 | New BC |
| de_o | output | 16 | New DE |
| hl_o | output | 16 | New HL |
| acc_o | output | 32 | New accumulator |
| ax_we | output | 1 | AX write enable |
| bc_we | output | 1 | BC write enable |
| de_we | output | 1 | DE write enable |
| hl_we | output | 1 | HL write enable |
| acc_we | output | 1 | Accumulator write enable |
| flag_we | output | 1 | Flag write enable |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary-carry flag |

## Verification
Results are due a fixed number of edges after the one that accepts the request:
- byte multiply: after that same edge;
- word multiplies: one edge later;
- accumulates: two edges later;
- short divide: eight edges later;
- long divide: sixteen edges later.

The bench raises `start` on a falling edge and changes every operand input right after acceptance, so any result built from live inputs instead of captured ones shows up. It then counts falling edges until `done` appears, and compares that count with the required latency. Values and enables are read on the falling edge where `done` is first high. One falling edge later the bench confirms that `done` and the enables have dropped while every result stayed put.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [2:0] {
      MD_MUL_BYTE = 3'd0,
      MD_MUL_S    = 3'd1,
      MD_MUL_U    = 3'd2,
      MD_DIV_W    = 3'd3,
      MD_DIV_L    = 3'd4,
      MD_MAC_S    = 3'd5,
      MD_MAC_U    = 3'd6
   } md_op_e;

   localparam int LAT_MUL_BYTE = 1;
   localparam int LAT_MUL_WORD = 2;
   localparam int LAT_MAC      = 3;

endpackage

// File: rtl/mdm_mul.sv
module mdm_mul #(
   parameter int W = 16
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           is_signed,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   logic [PW-1:0] xa, xb;

   // sign- or zero-extend to full product width; low PW bits are then exact
   assign xa   = {{W{is_signed & a[W-1]}}, a};
   assign xb   = {{W{is_signed & b[W-1]}}, b};
   assign prod = xa * xb;

   generate
      if (W < 2) begin : g_bad_w
         $error("mdm_mul: W must be at least 2");
      end
   endgenerate
endmodule

// File: rtl/mdm_divider.sv
module mdm_divider #(
   parameter int W    = 32,
   parameter int STEP = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         advance,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quot_nx,
   output logic [W-1:0] rem_nx
);
   logic [W-1:0] shf_q, quo_q, rem_q, dvs_q;
   logic [W-1:0] shf_c [STEP+1];
   logic [W-1:0] quo_c [STEP+1];
   logic [W-1:0] rem_c [STEP+1];

   assign shf_c[0] = shf_q;
   assign quo_c[0] = quo_q;
   assign rem_c[0] = rem_q;

   // STEP restoring iterations chained within one clock
   generate
      for (genvar s = 0; s < STEP; s++) begin : g_stage
         logic [W:0] trial;
         assign trial = {rem_c[s], shf_c[s][W-1]} - {1'b0, dvs_q};
         assign rem_c[s+1] = trial[W] ? {rem_c[s][W-2:0], shf_c[s][W-1]}
                                      : trial[W-1:0];
         assign quo_c[s+1] = {quo_c[s][W-2:0], ~trial[W]};
         assign shf_c[s+1] = {shf_c[s][W-2:0], 1'b0};
      end
      if (STEP < 1 || (W % STEP) != 0) begin : g_bad_step
         $error("mdm_divider: STEP must divide W");
      end
   endgenerate

   assign quot_nx = quo_c[STEP];
   assign rem_nx  = rem_c[STEP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shf_q <= '0;
         quo_q <= '0;
         rem_q <= '0;
         dvs_q <= '0;
      end else if (load) begin
         shf_q <= dividend;
         quo_q <= '0;
         rem_q <= '0;
         dvs_q <= divisor;
      end else if (advance) begin
         shf_q <= shf_c[STEP];
         quo_q <= quo_c[STEP];
         rem_q <= rem_c[STEP];
      end
   end

   // partial remainder always stays below a nonzero divisor (R4, R5)
   assert_partial_rem_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/md_arith_unit.sv
module md_arith_unit
   import mdu_pkg::*;
#(
   parameter int REG_W    = 16,
   parameter int DIV_STEP = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [2:0]         op_sel,
   input  logic [REG_W-1:0]   ax_i,
   input  logic [REG_W-1:0]   bc_i,
   input  logic [REG_W-1:0]   de_i,
   input  logic [REG_W-1:0]   hl_i,
   input  logic [2*REG_W-1:0] acc_i,
   output logic               busy,
   output logic               done,
   output logic [REG_W-1:0]   ax_o,
   output logic [REG_W-1:0]   bc_o,
   output logic [REG_W-1:0]   de_o,
   output logic [REG_W-1:0]   hl_o,
   output logic [2*REG_W-1:0] acc_o,
   output logic               ax_we,
   output logic               bc_we,
   output logic               de_we,
   output logic               hl_we,
   output logic               acc_we,
   output logic               flag_we,
   output logic               cy_o,
   output logic               ac_o
);
   localparam int ACC_W    = 2 * REG_W;
   localparam int HALF     = REG_W / 2;
   localparam int LAT_DIVW = REG_W / DIV_STEP + 1;
   localparam int LAT_DIVL = ACC_W / DIV_STEP + 1;
   localparam int CNT_W    = $clog2(LAT_DIVL + 1);

   generate
      if (REG_W < 4 || (REG_W % 2) != 0) begin : g_bad_reg
         $error("md_arith_unit: REG_W must be even and at least 4");
      end
      if (DIV_STEP < 1 || (REG_W % DIV_STEP) != 0) begin : g_bad_div
         $error("md_arith_unit: DIV_STEP must divide REG_W");
      end
   endgenerate

   md_op_e            op_d, op_q, c_op;
   logic              op_ok, accept, commit, is_div_d;
   logic [CNT_W-1:0]  lat_d, cnt_q;
   logic [REG_W-1:0]  ma, mb;
   logic              msig;
   logic [ACC_W-1:0]  prod, acc_sum, pend_d, pend_q, c_pend;
   logic              cy_d, ac_d, pcy_q, pac_q, c_cy, c_ac;
   logic [ACC_W-1:0]  dvd, dvs, quot_nx, rem_nx;

   assign op_d     = md_op_e'(op_sel);
   assign op_ok    = (op_sel <= 3'(MD_MAC_U));
   assign accept   = start && !busy && op_ok;
   assign is_div_d = (op_d == MD_DIV_W) || (op_d == MD_DIV_L);
   assign commit   = (accept && lat_d == CNT_W'(1)) || (busy && cnt_q == CNT_W'(1));
   assign c_op     = busy ? op_q   : op_d;
   assign c_pend   = busy ? pend_q : pend_d;
   assign c_cy     = busy ? pcy_q  : cy_d;
   assign c_ac     = busy ? pac_q  : ac_d;

   always_comb begin
      case (op_d)
         MD_MUL_BYTE:        lat_d = CNT_W'(LAT_MUL_BYTE);
         MD_MUL_S, MD_MUL_U: lat_d = CNT_W'(LAT_MUL_WORD);
         MD_DIV_W:           lat_d = CNT_W'(LAT_DIVW);
         MD_DIV_L:           lat_d = CNT_W'(LAT_DIVL);
         default:            lat_d = CNT_W'(LAT_MAC);
      endcase
   end

   // one shared multiplier; the byte form feeds the two halves of AX
   always_comb begin
      if (op_d == MD_MUL_BYTE) begin
         ma   = {{HALF{1'b0}}, ax_i[REG_W-1:HALF]};
         mb   = {{HALF{1'b0}}, ax_i[HALF-1:0]};
         msig = 1'b0;
      end else begin
         ma   = ax_i;
         mb   = bc_i;
         msig = (op_d == MD_MUL_S) || (op_d == MD_MAC_S);
      end
   end

   mdm_mul #(.W(REG_W)) u_mul (
      .a(ma), .b(mb), .is_signed(msig), .prod(prod)
   );

   assign acc_sum = acc_i + prod;

   always_comb begin
      pend_d = prod;
      cy_d   = 1'b0;
      ac_d   = 1'b0;
      if (op_d == MD_MAC_S) begin
         pend_d = acc_sum;
         cy_d   = acc_i[ACC_W-1] ^ acc_sum[ACC_W-1];
         ac_d   = acc_sum[ACC_W-1];
      end else if (op_d == MD_MAC_U) begin
         pend_d = acc_sum;
         cy_d   = (acc_sum < acc_i);
      end
   end

   // short divide left-justifies AX so only REG_W bit steps are needed
   assign dvd = (op_d == MD_DIV_W) ? {ax_i, {REG_W{1'b0}}} : {bc_i, ax_i};
   assign dvs = (op_d == MD_DIV_W) ? {{REG_W{1'b0}}, de_i}  : {hl_i, de_i};

   mdm_divider #(.W(ACC_W), .STEP(DIV_STEP)) u_div (
      .clk(clk), .rst_n(rst_n),
      .load(accept && is_div_d),
      .advance(busy && cnt_q != CNT_W'(1)),
      .dividend(dvd), .divisor(dvs),
      .quot_nx(quot_nx), .rem_nx(rem_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cnt_q   <= '0;
         op_q    <= MD_MUL_BYTE;
         pend_q  <= '0;
         pcy_q   <= 1'b0;
         pac_q   <= 1'b0;
         ax_o    <= '0;
         bc_o    <= '0;
         de_o    <= '0;
         hl_o    <= '0;
         acc_o   <= '0;
         cy_o    <= 1'b0;
         ac_o    <= 1'b0;
         ax_we   <= 1'b0;
         bc_we   <= 1'b0;
         de_we   <= 1'b0;
         hl_we   <= 1'b0;
         acc_we  <= 1'b0;
         flag_we <= 1'b0;
      end else begin
         done    <= commit;
         ax_we   <= 1'b0;
         bc_we   <= 1'b0;
         de_we   <= 1'b0;
         hl_we   <= 1'b0;
         acc_we  <= 1'b0;
         flag_we <= 1'b0;
         if (accept) begin
            op_q   <= op_d;
            pend_q <= pend_d;
            pcy_q  <= cy_d;
            pac_q  <= ac_d;
         end
         if (accept && lat_d != CNT_W'(1)) begin
            busy  <= 1'b1;
            cnt_q <= lat_d - CNT_W'(1);
         end else if (busy) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) busy <= 1'b0;
         end
         if (commit) begin
            case (c_op)
               MD_MUL_BYTE: begin
                  ax_o  <= c_pend[REG_W-1:0];
                  ax_we <= 1'b1;
               end
               MD_MUL_S, MD_MUL_U: begin
                  ax_o  <= c_pend[REG_W-1:0];
                  bc_o  <= c_pend[ACC_W-1:REG_W];
                  ax_we <= 1'b1;
                  bc_we <= 1'b1;
               end
               MD_DIV_W: begin
                  ax_o  <= quot_nx[REG_W-1:0];
                  de_o  <= rem_nx[REG_W-1:0];
                  ax_we <= 1'b1;
                  de_we <= 1'b1;
               end
               MD_DIV_L: begin
                  ax_o  <= quot_nx[REG_W-1:0];
                  bc_o  <= quot_nx[ACC_W-1:REG_W];
                  de_o  <= rem_nx[REG_W-1:0];
                  hl_o  <= rem_nx[ACC_W-1:REG_W];
                  ax_we <= 1'b1;
                  bc_we <= 1'b1;
                  de_we <= 1'b1;
                  hl_we <= 1'b1;
               end
               default: begin
                  acc_o   <= c_pend;
                  cy_o    <= c_cy;
                  ac_o    <= c_ac;
                  acc_we  <= 1'b1;
                  flag_we <= 1'b1;
               end
            endcase
         end
      end
   end

   assert_we_only_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ax_we || bc_we || de_we || hl_we || acc_we || flag_we) |-> done);

   assert_op_held_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q != CNT_W'(1)) |=> (busy && $stable(op_q)));

   assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(ax_o) && $stable(bc_o) && $stable(de_o) && $stable(hl_o)
                 && $stable(acc_o) && $stable(cy_o) && $stable(ac_o)));

   assert_macu_ac_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_q == MD_MAC_U) |-> !ac_o);

   assert_macs_ac_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_q == MD_MAC_S) |-> (ac_o == acc_o[ACC_W-1]));

   assert_busy_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt_q != '0));
endmodule

// File: tb/test_md_arith_unit.sv
module test_md_arith_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [15:0] ax_i = '0, bc_i = '0, de_i = '0, hl_i = '0;
   logic [31:0] acc_i = '0;
   logic        busy, done;
   logic [15:0] ax_o, bc_o, de_o, hl_o;
   logic [31:0] acc_o;
   logic        ax_we, bc_we, de_we, hl_we, acc_we, flag_we, cy_o, ac_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   md_arith_unit i_md_arith_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
      .ax_i(ax_i), .bc_i(bc_i), .de_i(de_i), .hl_i(hl_i), .acc_i(acc_i),
      .busy(busy), .done(done),
      .ax_o(ax_o), .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .acc_o(acc_o),
      .ax_we(ax_we), .bc_we(bc_we), .de_we(de_we), .hl_we(hl_we),
      .acc_we(acc_we), .flag_we(flag_we), .cy_o(cy_o), .ac_o(ac_o)
   );

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   function automatic logic [5:0] wes();
      return {ax_we, bc_we, de_we, hl_we, acc_we, flag_we};
   endfunction

   function automatic logic [113:0] outs();
      return {ax_o, bc_o, de_o, hl_o, acc_o, cy_o, ac_o};
   endfunction

   // issue one request, return how many falling edges until done; poke > 0
   // raises a byte-multiply request during the busy window
   task automatic run_case(input logic [2:0] o, input logic [15:0] a,
                           input logic [15:0] b, input logic [15:0] d,
                           input logic [15:0] h, input logic [31:0] c,
                           input int poke);
      string tag;
      int lat, seen;
      logic [5:0]  ewe;
      logic [15:0] eax, ebc, ede, ehl;
      logic [31:0] eacc, p, nsum, dd, dv;
      logic        ecy, eac;
      logic [113:0] snap;
      eax = ax_o; ebc = bc_o; ede = de_o; ehl = hl_o; eacc = acc_o;
      ecy = cy_o; eac = ac_o;
      case (o)
         3'd0: begin tag = "R1"; lat = 1; ewe = 6'b100000;
            eax = {8'h00, a[15:8]} * {8'h00, a[7:0]}; end
         3'd1: begin tag = "R2"; lat = 2; ewe = 6'b110000;
            p = {{16{a[15]}}, a} * {{16{b[15]}}, b};
            eax = p[15:0]; ebc = p[31:16]; end
         3'd2: begin tag = "R3"; lat = 2; ewe = 6'b110000;
            p = {16'h0, a} * {16'h0, b};
            eax = p[15:0]; ebc = p[31:16]; end
         3'd3: begin tag = "R4"; lat = 9; ewe = 6'b101000;
            if (d == 0) begin eax = 16'hFFFF; ede = a; end
            else begin eax = a / d; ede = a % d; end end
         3'd4: begin tag = "R5"; lat = 17; ewe = 6'b111100;
            dd = {b, a}; dv = {h, d};
            if (dv == 0) begin p = 32'hFFFF_FFFF; nsum = dd; end
            else begin p = dd / dv; nsum = dd % dv; end
            eax = p[15:0]; ebc = p[31:16]; ede = nsum[15:0]; ehl = nsum[31:16]; end
         3'd5: begin tag = "R6"; lat = 3; ewe = 6'b000011;
            p = {{16{a[15]}}, a} * {{16{b[15]}}, b};
            nsum = c + p; eacc = nsum; ecy = c[31] ^ nsum[31]; eac = nsum[31]; end
         default: begin tag = "R7"; lat = 3; ewe = 6'b000011;
            p = {16'h0, a} * {16'h0, b};
            nsum = c + p; eacc = nsum; ecy = (nsum < c); eac = 1'b0; end
      endcase
      @(negedge clk);
      op_sel = o; ax_i = a; bc_i = b; de_i = d; hl_i = h; acc_i = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ax_i = ~a; bc_i = ~b; de_i = ~d; hl_i = ~h; acc_i = ~c;
      seen = 0;
      for (int i = 1; i <= 40; i++) begin
         if (poke > 0 && i == poke) begin op_sel = 3'd0; ax_i = 16'h0303; start = 1'b1; end
         if (poke > 0 && i == poke + 1) start = 1'b0;
         if (done) begin seen = i; break; end
         @(negedge clk);
      end
      check(tag, "latency", 64'(seen), 64'(lat));
      check("R8", "write enables", 64'(wes()), 64'(ewe));
      check(tag, "ax", 64'(ax_o), 64'(eax));
      check(tag, "bc", 64'(bc_o), 64'(ebc));
      check(tag, "de", 64'(de_o), 64'(ede));
      check(tag, "hl", 64'(hl_o), 64'(ehl));
      check(tag, "acc", 64'(acc_o), 64'(eacc));
      check(tag, "cy", 64'(cy_o), 64'(ecy));
      check(tag, "ac", 64'(ac_o), 64'(eac));
      snap = outs();
      start = 1'b0;
      @(negedge clk);
      check("R8", "done pulse width", 64'(done), 64'(0));
      check("R8", "enables after done", 64'(wes()), 64'(0));
      check("R10", "outputs held", 64'(outs() != snap), 64'(0));
      if (poke > 0) begin
         repeat (3) @(negedge clk);
         check("R9", "no extra done", 64'(done || busy), 64'(0));
         check("R9", "outputs untouched", 64'(outs() != snap), 64'(0));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [113:0] snap;
      repeat (3) @(negedge clk);
      check("R11", "busy/done in reset", 64'({busy, done}), 64'(0));
      check("R11", "enables in reset", 64'(wes()), 64'(0));
      check("R11", "outputs in reset", 64'(outs() != '0), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // corner cases
      run_case(3'd0, 16'hFFFF, 0, 0, 0, 0, 0);          // R1 max bytes
      run_case(3'd0, 16'h0000, 0, 0, 0, 0, 0);          // R1 zero
      run_case(3'd1, 16'h8000, 16'h8000, 0, 0, 0, 0);   // R2 most negative squared
      run_case(3'd1, 16'hFFFF, 16'h7FFF, 0, 0, 0, 0);   // R2 -1 * max
      run_case(3'd2, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0);   // R3 max unsigned
      run_case(3'd3, 16'h1234, 0, 16'h0000, 0, 0, 0);   // R4 divide by zero
      run_case(3'd3, 16'hFFFF, 0, 16'h0001, 0, 0, 0);   // R4 divide by one
      run_case(3'd3, 16'h0005, 0, 16'hFFFF, 0, 0, 0);   // R4 divisor > dividend
      run_case(3'd4, 16'h5678, 16'h1234, 16'h0000, 16'h0000, 0, 0); // R5 zero
      run_case(3'd4, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 0, 0); // R5 by one
      run_case(3'd4, 16'h0000, 16'h8000, 16'hFFFF, 16'hFFFF, 0, 0); // R5 large divisor
      run_case(3'd5, 16'h0001, 16'h0001, 0, 0, 32'h7FFF_FFFF, 0);   // R6 sign flips
      run_case(3'd5, 16'hFFFF, 16'h0001, 0, 0, 32'h0000_0000, 0);   // R6 goes negative
      run_case(3'd6, 16'h0001, 16'h0001, 0, 0, 32'hFFFF_FFFF, 0);   // R7 wraps
      run_case(3'd6, 16'hFFFF, 16'hFFFF, 0, 0, 32'h0000_0001, 0);   // R7 no wrap

      // sweeps over every operation with pseudo-random operands
      for (int o = 0; o < 7; o++) begin
         for (int n = 0; n < 24; n++) begin
            logic [31:0] r1, r2, r3;
            logic [15:0] dv, hv;
            r1 = rnd(); r2 = rnd(); r3 = rnd();
            dv = r2[15:0];
            hv = r2[31:16];
            if (n % 4 == 1) dv = dv & 16'h000F;
            if (n % 5 == 2) dv = 16'h0000;
            if (n % 2 == 0) hv = 16'h0000;
            run_case(3'(o), r1[15:0], r1[31:16], dv, hv, r3, 0);
         end
      end

      // R9: request during a long divide is ignored
      run_case(3'd4, 16'hBEEF, 16'h00AB, 16'h0007, 16'h0000, 0, 3);
      run_case(3'd3, 16'hC350, 0, 16'h0064, 0, 0, 5);

      // R9: reserved operation code is ignored
      snap = outs();
      @(negedge clk);
      op_sel = 3'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 5; i++) begin
         check("R9", "reserved op done/busy", 64'({done, busy}), 64'(0));
         check("R9", "reserved op enables", 64'(wes()), 64'(0));
         @(negedge clk);
      end
      check("R10", "reserved op outputs held", 64'(outs() != snap), 64'(0));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule